// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes an incoming frame as a byte stream, one byte per valid beat, and stores its accounting in a ring of receive descriptors. The descriptors sit in a small RAM inside the block. The host reads and writes that RAM through a word port. A descriptor is usable only while its ownership bit marks it as belonging to the engine. The engine counts each frame's bytes into the buffer that the current descriptor describes. When the buffer is full, the frame carries on into the next descriptor. When the frame ends, the engine writes the status flags and the message length back and returns the descriptor to the host.

The engine signals each completed frame with a one-cycle receive pulse. If a frame starts while the descriptor at the ring position is still held by the host, the whole frame is discarded and a one-cycle missed-frame pulse is raised. The ring size is a power of two, taken from a 3-bit log2 field. That field is clamped to the depth built into the RAM. The data bytes themselves are not stored: only their count is kept.

Top module: `rxr_engine`

## Requirements
- R1: After reset, `rint` and `miss` are low, every descriptor word reads 0, and the first frame is placed in entry 0.
- R2: Each entry has four 16-bit words. Word 0 is the buffer address low. Word 1 holds the flag byte in bits 15:8 and the address high byte in bits 7:0. Word 2 is the buffer length as a two's complement with bits 15:12 set, so capacity = (-word) mod 4096, with 0 meaning 4096. Word 3 carries the message length in bits 11:0. The host port returns what was written, and the engine never changes words 0 and 2 or the low byte of word 1.
- R3: Flag bits are ENP 0x01, STP 0x02, BUFF 0x04, CRC 0x08, OFLO 0x10, FRAM 0x20, ERR 0x40 and OWN 0x80, where OWN=1 means the engine owns the entry. A clean frame that fits one buffer leaves the flag byte at exactly 0x03 and the message length equal to the frame's beat count, which includes the 4 CRC bytes.
- R4: `rint` is high for one cycle, in the cycle after the last beat of a frame whose descriptor carries ENP. It is high once per such frame.
- R5: A frame longer than its buffer fills that buffer to exact capacity and continues in the next entry. The first entry is returned with flags 0x02 and message length 0. The final entry gets ENP (without STP) and the total frame length.
- R6: A CRC or framing error flagged on the last beat sets CRC or FRAM, plus ERR, only on the entry that carries ENP. ERR is set exactly when any of BUFF, CRC, OFLO or FRAM is set.
- R7: If a frame starts while the entry at the ring position has OWN=0, `miss` pulses once in the next cycle. No entry changes, and the ring position does not advance.
- R8: If a buffer fills before the frame's last beat and the next entry is host-owned, the current entry is returned with ENP, BUFF, OFLO and ERR (plus STP if it was the first) and the length received so far. `rint` pulses, the rest of the frame is discarded, and the ring position moves to the next entry.
- R9: `ring_log` gives log2 of the ring size. The position advances modulo that size, so after the last entry the next frame goes to entry 0.
- R10: If the host returns an entry in the same cycle as a frame starts on it, the engine sees the entry as host-owned and counts a miss. The host's write is kept.
- R11: In a cycle where the engine writes an entry back, a host write to another entry also takes effect. On the same word, the engine's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_log | input | 3 | log2 of the ring size (ring-length word bits 15:13) |
| rx_valid | input | 1 | One frame byte on this beat |
| rx_last | input | 1 | Beat is the last of the frame |
| rx_crc_err | input | 1 | CRC error, sampled with the last beat |
| rx_fram_err | input | 1 | Framing error, sampled with the last beat |
| host_we | input | 1 | Host write to descriptor RAM |
| host_entry | input | MAX_LOG | Host-addressed entry |
| host_word | input | 2 | Host-addressed word in the entry |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Addressed word, combinational |
| rint | output | 1 | Frame-received pulse |
| miss | output | 1 | Missed-frame pulse |

## Verification
Two pairs of events can fall in the same cycle. The first is the host handing an entry back while a frame's first beat arrives on that same entry. The second is the host writing the RAM while the engine writes an entry back. The bench provokes both by issuing the host write on exactly the beat in question. It then judges the result at the host port: a miss, with the host's word kept; the engine's flags on a shared word; and both updates landing when the two writes touch different entries.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int FB_ENP  = 0;
  localparam int FB_STP  = 1;
  localparam int FB_BUFF = 2;
  localparam int FB_CRC  = 3;
  localparam int FB_OFLO = 4;
  localparam int FB_FRAM = 5;
  localparam int FB_ERR  = 6;
  localparam int FB_OWN  = 7;
  localparam int DW      = 16;
  localparam int WPE     = 4;

  typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_DROP} rx_state_e;

  // Capacity from a negated 12-bit length field; zero means 4096 bytes.
  function automatic logic [12:0] buf_bytes(input logic [11:0] neg_len);
    logic [11:0] n;
    n = 12'(~neg_len + 12'd1);
    return (n == 12'd0) ? 13'd4096 : {1'b0, n};
  endfunction

  // Adds the error-summary bit when any individual error bit is set.
  function automatic logic [7:0] with_summary(input logic [7:0] f);
    return (|f[5:2]) ? (f | 8'h40) : f;
  endfunction

  function automatic int eff_log(input logic [2:0] lg, input int maxlog);
    return (int'(lg) > maxlog) ? maxlog : int'(lg);
  endfunction
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram import rxr_pkg::*; #(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [IDXW-1:0] host_entry,
  input  logic [1:0]      host_word,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic [IDXW-1:0] eng_entry,
  input  logic [IDXW-1:0] nxt_entry,
  output logic            eng_own,
  output logic [11:0]     eng_len12,
  output logic            nxt_own,
  input  logic            wb_en,
  input  logic [IDXW-1:0] wb_entry,
  input  logic [7:0]      wb_flag,
  input  logic [11:0]     wb_mlen
);
  localparam int ENTRIES = 1 << IDXW;
  localparam int EW      = DW * WPE;

  logic [EW-1:0] flat [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [EW-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else begin
        for (int w = 0; w < WPE; w++)
          if (host_we && host_entry == IDXW'(e) && host_word == 2'(w))
            ent_q[w*DW +: DW] <= host_wdata;
        // engine write-back overrides a host write to the same word
        if (wb_en && wb_entry == IDXW'(e)) begin
          ent_q[1*DW +: DW] <= {wb_flag, ent_q[1*DW +: 8]};
          ent_q[3*DW +: DW] <= {4'h0, wb_mlen};
        end
      end
    end
    assign flat[e] = ent_q;
  end

  assign host_rdata = flat[host_entry][host_word*DW +: DW];
  assign eng_own    = flat[eng_entry][1*DW + 8 + FB_OWN];
  assign eng_len12  = flat[eng_entry][2*DW +: 12];
  assign nxt_own    = flat[nxt_entry][1*DW + 8 + FB_OWN];
endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl import rxr_pkg::*; #(
  parameter int MAX_LOG = 4,
  parameter int IDXW    = MAX_LOG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      ring_log,
  input  logic            rx_valid,
  input  logic            rx_last,
  input  logic            rx_crc_err,
  input  logic            rx_fram_err,
  input  logic            eng_own,
  input  logic [11:0]     eng_len12,
  input  logic            nxt_own,
  output logic [IDXW-1:0] idx,
  output logic [IDXW-1:0] nxt_idx,
  output logic [IDXW-1:0] ring_mask,
  output logic            frame_start,
  output logic            wb_en,
  output logic [7:0]      wb_flag,
  output logic [11:0]     wb_mlen,
  output logic            rint,
  output logic            miss
);
  rx_state_e   st, nst;
  logic        first, nfirst, cur_first, accept, rint_d, miss_d;
  logic [12:0] bcnt, total, nb, nt, cur_b, cur_t, bn, tn;
  logic [IDXW-1:0] nidx;
  logic [7:0]  f;

  assign ring_mask = IDXW'((32'd1 << eff_log(ring_log, MAX_LOG)) - 32'd1);
  assign nxt_idx   = IDXW'(idx + IDXW'(1)) & ring_mask;

  always_comb begin
    nst = st; nidx = idx; nfirst = first; nb = bcnt; nt = total;
    wb_en = 1'b0; wb_flag = '0; wb_mlen = '0; rint_d = 1'b0; miss_d = 1'b0;
    f = '0;
    frame_start = rx_valid && (st == RX_IDLE);
    accept      = rx_valid && ((st == RX_FILL) || (frame_start && eng_own));
    cur_first   = (st == RX_IDLE) || first;
    cur_b       = (st == RX_IDLE) ? 13'd0 : bcnt;
    cur_t       = (st == RX_IDLE) ? 13'd0 : total;
    bn          = cur_b + 13'd1;
    tn          = cur_t + 13'd1;
    f[FB_STP]   = cur_first;
    if (frame_start && !eng_own) begin
      miss_d = 1'b1;
      if (!rx_last) nst = RX_DROP;
    end
    if (st == RX_DROP && rx_valid && rx_last) nst = RX_IDLE;
    if (accept) begin
      if (rx_last) begin
        f[FB_ENP] = 1'b1; f[FB_CRC] = rx_crc_err; f[FB_FRAM] = rx_fram_err;
        wb_en = 1'b1; wb_flag = with_summary(f); wb_mlen = tn[11:0];
        rint_d = 1'b1; nidx = nxt_idx; nst = RX_IDLE;
      end else if (bn == buf_bytes(eng_len12)) begin
        wb_en = 1'b1; nidx = nxt_idx;
        if (nxt_own) begin
          wb_flag = f; nst = RX_FILL; nfirst = 1'b0; nb = '0; nt = tn;
        end else begin
          f[FB_ENP] = 1'b1; f[FB_BUFF] = 1'b1; f[FB_OFLO] = 1'b1;
          wb_flag = with_summary(f); wb_mlen = tn[11:0];
          rint_d = 1'b1; nst = RX_DROP;
        end
      end else begin
        nst = RX_FILL; nfirst = cur_first; nb = bn; nt = tn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; idx <= '0; first <= 1'b0; bcnt <= '0; total <= '0;
      rint <= 1'b0; miss <= 1'b0;
    end else begin
      st <= nst; idx <= nidx; first <= nfirst; bcnt <= nb; total <= nt;
      rint <= rint_d; miss <= miss_d;
    end
  end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine import rxr_pkg::*; #(
  parameter int MAX_LOG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         ring_log,
  input  logic               rx_valid,
  input  logic               rx_last,
  input  logic               rx_crc_err,
  input  logic               rx_fram_err,
  input  logic               host_we,
  input  logic [MAX_LOG-1:0] host_entry,
  input  logic [1:0]         host_word,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               rint,
  output logic               miss
);
  localparam int IDXW = MAX_LOG;

  logic [IDXW-1:0] idx, nxt_idx, ring_mask;
  logic            eng_own, nxt_own, frame_start, wb_en;
  logic [11:0]     eng_len12, wb_mlen;
  logic [7:0]      wb_flag;

  rxr_desc_ram #(.IDXW(IDXW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_entry(host_entry), .host_word(host_word),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_entry(idx), .nxt_entry(nxt_idx),
    .eng_own(eng_own), .eng_len12(eng_len12), .nxt_own(nxt_own),
    .wb_en(wb_en), .wb_entry(idx), .wb_flag(wb_flag), .wb_mlen(wb_mlen)
  );

  rxr_ring_ctrl #(.MAX_LOG(MAX_LOG), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ring_log(ring_log),
    .rx_valid(rx_valid), .rx_last(rx_last),
    .rx_crc_err(rx_crc_err), .rx_fram_err(rx_fram_err),
    .eng_own(eng_own), .eng_len12(eng_len12), .nxt_own(nxt_own),
    .idx(idx), .nxt_idx(nxt_idx), .ring_mask(ring_mask),
    .frame_start(frame_start), .wb_en(wb_en), .wb_flag(wb_flag),
    .wb_mlen(wb_mlen), .rint(rint), .miss(miss)
  );
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk #(
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rint,
  input logic            miss,
  input logic            frame_start,
  input logic            eng_own,
  input logic            wb_en,
  input logic [7:0]      wb_flag,
  input logic [IDXW-1:0] idx,
  input logic [IDXW-1:0] ring_mask
);
  AST_RINT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wb_flag[0]) |=> rint); // R4
  AST_RINT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rint |-> $past(wb_en && wb_flag[0])); // R4
  AST_WB_TO_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !wb_flag[7]); // R3
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_flag[6] == (|wb_flag[5:2]))); // R6
  AST_CHAIN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !wb_flag[0]) |-> (wb_flag[6:2] == 5'd0)); // R5
  AST_MISS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> $past(frame_start && !eng_own)); // R7
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rint, miss})); // R7
  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (idx & ~ring_mask) == '0); // R9
endmodule

bind rxr_engine rxr_engine_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rint(rint), .miss(miss),
  .frame_start(frame_start), .eng_own(eng_own), .wb_en(wb_en),
  .wb_flag(wb_flag), .idx(idx), .ring_mask(ring_mask)
);

// File: tb/rxr_engine_bench.sv
module rxr_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  ring_log = 3'd3;
  logic rx_valid = 0, rx_last = 0, rx_crc_err = 0, rx_fram_err = 0;
  logic host_we = 0;
  logic [3:0]  host_entry = '0;
  logic [1:0]  host_word = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic rint, miss;
  int checks = 0, fails = 0, rint_cnt = 0, miss_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxr_engine u_rxr_engine (
    .clk(clk), .rst_n(rst_n), .ring_log(ring_log), .rx_valid(rx_valid),
    .rx_last(rx_last), .rx_crc_err(rx_crc_err), .rx_fram_err(rx_fram_err),
    .host_we(host_we), .host_entry(host_entry), .host_word(host_word),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rint(rint), .miss(miss)
  );

  always @(negedge clk) begin
    if (rint) rint_cnt++;
    if (miss) miss_cnt++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] neg_len(input int b);
    return 16'(0 - b) | 16'hF000;
  endfunction

  task automatic wr(input int e, input int w, input logic [15:0] d);
    @(negedge clk);
    host_we = 1; host_entry = 4'(e); host_word = 2'(w); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input int e, input int w, output logic [15:0] v);
    host_entry = 4'(e); host_word = 2'(w);
    #1 v = host_rdata;
  endtask

  task automatic give(input int e, input int bytes);
    wr(e, 0, 16'h1000 + 16'(e));
    wr(e, 1, 16'h80A0 + 16'(e));
    wr(e, 2, neg_len(bytes));
    wr(e, 3, 16'h0);
  endtask

  task automatic send(input int n, input bit crc, input bit fram,
                      input int hw_beat, input int he, input int hw, input logic [15:0] hd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_last = (i == n - 1);
      rx_crc_err = crc && (i == n - 1); rx_fram_err = fram && (i == n - 1);
      if (i == hw_beat) begin
        host_we = 1; host_entry = 4'(he); host_word = 2'(hw); host_wdata = hd;
      end else host_we = 0;
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0; rx_crc_err = 0; rx_fram_err = 0; host_we = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_desc(input string req, input int e, input logic [15:0] w1, input logic [15:0] w3);
    logic [15:0] v;
    rd(e, 1, v); chk(req, $sformatf("entry %0d flags", e), v, w1);
    rd(e, 3, v); chk(req, $sformatf("entry %0d mlen", e), v, w3);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1", "rint", rint, 0);
    chk("R1", "miss", miss, 0);
    rd(0, 1, v); chk("R1", "entry0 word1", v, 0);
    rd(9, 2, v); chk("R1", "entry9 word2", v, 0);
  endtask

  task automatic t_layout();
    logic [15:0] v;
    wr(12, 0, 16'h1234); wr(12, 2, 16'hABCD);
    rd(12, 0, v); chk("R2", "word0 readback", v, 16'h1234);
    rd(12, 2, v); chk("R2", "word2 readback", v, 16'hABCD);
  endtask

  task automatic t_single();
    int r0 = rint_cnt;
    logic [15:0] v;
    give(0, 100);
    send(64, 0, 0, -1, 0, 0, 0);
    expect_desc("R3", 0, 16'h03A0, 16'd64);
    rd(0, 0, v); chk("R2", "entry0 addr low kept", v, 16'h1000);
    rd(0, 2, v); chk("R2", "entry0 length kept", v, neg_len(100));
    chk("R4", "rint pulses", rint_cnt - r0, 1);
    chk("R1", "first frame miss count", miss_cnt, 0);
  endtask

  task automatic t_chain();
    int r0 = rint_cnt;
    give(1, 32); give(2, 32);
    send(50, 1, 0, -1, 0, 0, 0);
    expect_desc("R5", 1, 16'h02A1, 16'd0);
    expect_desc("R6", 2, 16'h49A2, 16'd50);
    chk("R5", "one rint for chained frame", rint_cnt - r0, 1);
    give(3, 32);
    send(32, 0, 1, -1, 0, 0, 0);
    expect_desc("R6", 3, 16'h63A3, 16'd32);
  endtask

  task automatic t_miss();
    int m0 = miss_cnt, r0 = rint_cnt;
    send(10, 0, 0, -1, 0, 0, 0);
    chk("R7", "miss pulses", miss_cnt - m0, 1);
    chk("R7", "no rint", rint_cnt - r0, 0);
    expect_desc("R7", 4, 16'h0000, 16'h0000);
    give(4, 64);
    send(20, 0, 0, -1, 0, 0, 0);
    expect_desc("R7", 4, 16'h03A4, 16'd20);
  endtask

  task automatic t_overflow();
    int m0 = miss_cnt, r0 = rint_cnt;
    give(5, 16);
    send(40, 0, 0, -1, 0, 0, 0);
    expect_desc("R8", 5, 16'h57A5, 16'd16);
    chk("R8", "rint on overflow", rint_cnt - r0, 1);
    chk("R8", "no miss on overflow", miss_cnt - m0, 0);
    expect_desc("R8", 6, 16'h0000, 16'h0000);
    give(6, 64);
    send(8, 0, 0, -1, 0, 0, 0);
    expect_desc("R8", 6, 16'h03A6, 16'd8);
  endtask

  task automatic t_wrap();
    give(7, 64); give(0, 64);
    send(12, 0, 0, -1, 0, 0, 0);
    expect_desc("R9", 7, 16'h03A7, 16'd12);
    send(13, 0, 0, -1, 0, 0, 0);
    expect_desc("R9", 0, 16'h03A0, 16'd13);
  endtask

  task automatic t_collide();
    int m0 = miss_cnt;
    send(5, 0, 0, 0, 1, 1, 16'h80A1);
    chk("R10", "miss on same-cycle hand-over", miss_cnt - m0, 1);
    expect_desc("R10", 1, 16'h80A1, 16'd0);
    send(6, 0, 0, -1, 0, 0, 0);
    expect_desc("R10", 1, 16'h03A1, 16'd6);
  endtask

  task automatic t_parallel();
    logic [15:0] v;
    give(2, 64); give(3, 64);
    send(5, 0, 0, 4, 2, 1, 16'h80FF);
    expect_desc("R11", 2, 16'h03A2, 16'd5);
    send(7, 0, 0, 6, 5, 0, 16'hBEEF);
    expect_desc("R11", 3, 16'h03A3, 16'd7);
    rd(5, 0, v); chk("R11", "other-entry host write", v, 16'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_layout();
    t_single();
    t_chain();
    t_miss();
    t_overflow();
    t_wrap();
    t_collide();
    t_parallel();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule